// File: doc/BRIEF.md
# Low-Power Lane Sequence Decoder

This block sits on the receive side of a serial data lane. It watches the two single-ended low-power line levels as a 2-bit state on a fast system clock and turns the order of those states into events. The lines idle in the Stop state (both high). From Stop the block recognises three request sequences: a request to enter high-speed mode, a request to turn the bus around, and a request to enter escape mode. In escape mode it recovers bits from spaced-one-hot line coding. The first byte is a command. The command selects low-power data reception, ultra-low-power state or one of several trigger messages.

The block tracks ultra-low-power state and accepts a wake-up only when the wake mark lasted long enough. Any line change that does not fit the expected next state aborts the sequence and raises an error pulse. The decoder recovers on the Stop state. The input pair first passes through a parameterised synchroniser. The outputs are single-cycle event pulses, a 3-bit mode code, received data bytes with a valid strobe, and an error pulse.

Top module: `lp_seq_decoder`

## Requirements
- R1: After reset, mode_o reads IDLE (code 0) and every event pulse, rx_valid_o and err_o are low. Line input encoding: lp_i[1] is the positive line and lp_i[0] the negative line, so LP-10 is 2'b10.
- R2: From Stop, the sequence LP-10, LP-00, LP-01, LP-00 gives one esc_req_o pulse, and mode_o becomes ESC (code 1).
- R3: From Stop, the sequence LP-01, LP-00 gives one hs_req_o pulse, and mode_o becomes HS (code 4). The mode stays HS while the lines sit at LP-00 and returns to IDLE on LP-11.
- R4: From Stop, the sequence LP-10, LP-00, LP-10, LP-00 gives one bta_req_o pulse, and mode_o becomes TA (code 5). It returns to IDLE on LP-11.
- R5: In escape mode, LP-01 is Mark-0 and LP-10 is Mark-1. A bit is taken when the mark is followed by LP-00. Bits arrive least significant first, and the first 8 bits form the command byte.
- R6: If the command equals CMD_LPDT, mode_o becomes LPDT (code 2). Each further 8 bits then produce one rx_valid_o pulse with the byte on rx_byte_o.
- R7: If the command equals CMD_ULPS, ulps_enter_o pulses and mode_o becomes ULPS (code 3).
- R8: In ULPS, LP-10 held for at least WAKE_CYCLES clocks and then LP-11 gives one ulps_exit_o pulse and IDLE. A shorter LP-10, or LP-10 followed by any state other than LP-11, gives an err_o pulse and the mode stays ULPS.
- R9: If the command equals trigger code k (TRIG_CODES[8k+7:8k]), trig_o[k] pulses once. Any further bit before escape exit is an error.
- R10: In escape mode, Mark-1 followed directly by LP-11 gives one esc_exit_o pulse and IDLE.
- R11: A command matching no code gives an err_o pulse, and mode_o becomes ERR (code 6) until the lines reach LP-11.
- R12: Two marks with no LP-00 between them, or any change that is not the expected next state, give an err_o pulse. The mode becomes ERR if the new state is not LP-11, or IDLE if it is.
- R13: At most one of the event pulses, err_o, rx_valid_o and trig_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_i | input | 2 | Low-power line levels {positive, negative} |
| mode_o | output | 3 | Mode code (IDLE 0, ESC 1, LPDT 2, ULPS 3, HS 4, TA 5, ERR 6) |
| hs_req_o | output | 1 | High-speed entry recognised |
| esc_req_o | output | 1 | Escape entry recognised |
| bta_req_o | output | 1 | Bus turnaround recognised |
| ulps_enter_o | output | 1 | Ultra-low-power state entered |
| ulps_exit_o | output | 1 | Valid wake-up completed |
| esc_exit_o | output | 1 | Escape mode left normally |
| trig_o | output | NUM_TRIG | One pulse per recognised trigger command |
| rx_byte_o | output | 8 | Received low-power data byte |
| rx_valid_o | output | 1 | rx_byte_o valid strobe |
| err_o | output | 1 | Sequence error pulse |

## Verification
The bench builds the decoder with WAKE_CYCLES set to 40, a two-stage synchroniser and two trigger codes (0x62 and 0xA0). The short wake-up count lets a run test a too-short wake mark and a valid one in a few hundred cycles. Using two trigger codes shows that only the matching trigger bit pulses. The data bytes sent are not bit-palindromes, so a reversed bit order would show up in rx_byte_o.

// File: rtl/lpsd_pkg.sv
package lpsd_pkg;

   typedef enum logic [1:0] {
      LP00 = 2'b00,
      LP01 = 2'b01,
      LP10 = 2'b10,
      LP11 = 2'b11
   } lp_line_e;

   typedef enum logic [2:0] {
      MD_IDLE = 3'd0,
      MD_ESC  = 3'd1,
      MD_LPDT = 3'd2,
      MD_ULPS = 3'd3,
      MD_HS   = 3'd4,
      MD_TA   = 3'd5,
      MD_ERR  = 3'd6
   } lp_mode_e;

   typedef enum logic [3:0] {
      S_INIT, S_STOP, S_E1, S_E2, S_ESC_IN, S_TA_IN, S_HS_IN,
      S_HS, S_TA, S_SPACE, S_MARK, S_ULPS, S_WAKE, S_ERR
   } dec_state_e;

   typedef enum logic [1:0] {
      PH_CMD, PH_DATA, PH_DONE
   } esc_phase_e;

endpackage

// File: rtl/lpsd_line_sync.sv
module lpsd_line_sync #(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] lp_i,
   output logic [1:0] lp_o,
   output logic       chg_o
);
   logic [1:0] stage_q [STAGES];
   logic [1:0] prev_q;

   generate
      if (STAGES < 1) begin : g_bad
         $error("lpsd_line_sync: STAGES must be at least 1");
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[0] <= 2'b00;
         else        stage_q[0] <= lp_i;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= 2'b00;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 2'b00;
      else        prev_q <= stage_q[STAGES-1];
   end

   assign lp_o  = stage_q[STAGES-1];
   assign chg_o = (stage_q[STAGES-1] != prev_q);
endmodule

// File: rtl/lpsd_soh_shift.sv
module lpsd_soh_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         bit_valid_i,
   input  logic         bit_i,
   output logic [W-1:0] byte_o,
   output logic         done_o
);
   localparam int CW = (W > 1) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [W-1:0]  sr_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (clr_i) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (bit_valid_i) begin
         sr_q  <= byte_o;
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   // least significant bit arrives first: new bit enters at the top
   assign byte_o = {bit_i, sr_q[W-1:1]};
   assign done_o = bit_valid_i && (cnt_q == LAST);
endmodule

// File: rtl/lpsd_wake_timer.sv
module lpsd_wake_timer #(
   parameter int WAKE_CYCLES = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic run_i,
   output logic reached_o
);
   localparam int WCW = $clog2(WAKE_CYCLES + 1);
   localparam logic [WCW-1:0] LIMIT = WCW'(WAKE_CYCLES);

   logic [WCW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (start_i)                 cnt_q <= WCW'(1);
      else if (run_i && cnt_q < LIMIT)  cnt_q <= cnt_q + 1'b1;
   end

   assign reached_o = (cnt_q >= LIMIT);
endmodule

// File: rtl/lp_seq_decoder.sv
module lp_seq_decoder
   import lpsd_pkg::*;
#(
   parameter int                  SYNC_STAGES = 2,
   parameter int                  WAKE_CYCLES = 50000,
   parameter logic [7:0]          CMD_LPDT    = 8'hE1,
   parameter logic [7:0]          CMD_ULPS    = 8'h1E,
   parameter int                  NUM_TRIG    = 4,
   parameter logic [NUM_TRIG*8-1:0] TRIG_CODES = 32'hA0_21_5D_62
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          lp_i,
   output logic [2:0]          mode_o,
   output logic                hs_req_o,
   output logic                esc_req_o,
   output logic                bta_req_o,
   output logic                ulps_enter_o,
   output logic                ulps_exit_o,
   output logic                esc_exit_o,
   output logic [NUM_TRIG-1:0] trig_o,
   output logic [7:0]          rx_byte_o,
   output logic                rx_valid_o,
   output logic                err_o
);
   localparam int BW = 8;

   generate
      if (WAKE_CYCLES < 2) begin : g_bad_wake
         $error("lp_seq_decoder: WAKE_CYCLES must be at least 2");
      end
      if (NUM_TRIG < 1) begin : g_bad_trig
         $error("lp_seq_decoder: NUM_TRIG must be at least 1");
      end
      if (CMD_LPDT == CMD_ULPS) begin : g_bad_cmd
         $error("lp_seq_decoder: command codes must differ");
      end
   endgenerate

   logic [1:0] lp;
   logic       chg;

   lpsd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .lp_i(lp_i), .lp_o(lp), .chg_o(chg)
   );

   dec_state_e state_q, state_d;
   esc_phase_e phase_q, phase_d;
   logic       mark_q, mark_d;

   logic          bit_valid, shift_clr, byte_done;
   logic [BW-1:0] byte_w;

   lpsd_soh_shift #(.W(BW)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr_i(shift_clr), .bit_valid_i(bit_valid),
      .bit_i(mark_q), .byte_o(byte_w), .done_o(byte_done)
   );

   logic wake_start, wake_reached;

   lpsd_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
      .clk(clk), .rst_n(rst_n), .start_i(wake_start),
      .run_i(state_q == S_WAKE), .reached_o(wake_reached)
   );

   logic [NUM_TRIG-1:0] trig_hit;
   generate
      for (genvar k = 0; k < NUM_TRIG; k++) begin : g_trig
         assign trig_hit[k] = (byte_w == TRIG_CODES[k*8 +: 8]);
      end
   endgenerate

   logic                hs_d, esc_d, bta_d, uen_d, uex_d, exit_d, rxv_d, err_d;
   logic [NUM_TRIG-1:0] trig_d;
   logic [BW-1:0]       rxb_d, rxb_q;

   assign bit_valid  = (state_q == S_MARK) && chg && (lp == LP00);
   assign wake_start = (state_q == S_ULPS) && chg && (lp == LP10);

   always_comb begin
      state_d   = state_q;
      phase_d   = phase_q;
      mark_d    = mark_q;
      shift_clr = 1'b0;
      hs_d = 1'b0; esc_d = 1'b0; bta_d = 1'b0; uen_d = 1'b0;
      uex_d = 1'b0; exit_d = 1'b0; rxv_d = 1'b0; err_d = 1'b0;
      trig_d = '0;
      rxb_d  = rxb_q;

      case (state_q)
         S_INIT: if (lp == LP11) state_d = S_STOP;
         S_ERR:  if (lp == LP11) state_d = S_STOP;
         S_STOP: if (chg) begin
            if      (lp == LP10) state_d = S_E1;
            else if (lp == LP01) state_d = S_HS_IN;
            else begin state_d = S_ERR; err_d = 1'b1; end
         end
         S_E1: if (chg) begin
            if (lp == LP00) state_d = S_E2;
            else begin state_d = (lp == LP11) ? S_STOP : S_ERR; err_d = 1'b1; end
         end
         S_E2: if (chg) begin
            if      (lp == LP01) state_d = S_ESC_IN;
            else if (lp == LP10) state_d = S_TA_IN;
            else begin state_d = (lp == LP11) ? S_STOP : S_ERR; err_d = 1'b1; end
         end
         S_ESC_IN: if (chg) begin
            if (lp == LP00) begin
               state_d = S_SPACE; phase_d = PH_CMD; shift_clr = 1'b1; esc_d = 1'b1;
            end else begin state_d = (lp == LP11) ? S_STOP : S_ERR; err_d = 1'b1; end
         end
         S_TA_IN: if (chg) begin
            if (lp == LP00) begin state_d = S_TA; bta_d = 1'b1; end
            else begin state_d = (lp == LP11) ? S_STOP : S_ERR; err_d = 1'b1; end
         end
         S_HS_IN: if (chg) begin
            if (lp == LP00) begin state_d = S_HS; hs_d = 1'b1; end
            else begin state_d = (lp == LP11) ? S_STOP : S_ERR; err_d = 1'b1; end
         end
         S_HS, S_TA: if (chg && lp == LP11) state_d = S_STOP;
         S_SPACE: if (chg) begin
            if      (lp == LP01) begin state_d = S_MARK; mark_d = 1'b0; end
            else if (lp == LP10) begin state_d = S_MARK; mark_d = 1'b1; end
            else begin state_d = S_STOP; err_d = 1'b1; end
         end
         S_MARK: if (chg) begin
            if (lp == LP00) begin
               state_d = S_SPACE;
               if (phase_q == PH_DONE) begin
                  state_d = S_ERR; err_d = 1'b1;
               end else if (byte_done) begin
                  if (phase_q == PH_DATA) begin
                     rxv_d = 1'b1; rxb_d = byte_w;
                  end else if (byte_w == CMD_LPDT) begin
                     phase_d = PH_DATA;
                  end else if (byte_w == CMD_ULPS) begin
                     state_d = S_ULPS; uen_d = 1'b1;
                  end else if (|trig_hit) begin
                     trig_d = trig_hit; phase_d = PH_DONE;
                  end else begin
                     state_d = S_ERR; err_d = 1'b1;
                  end
               end
            end else if (lp == LP11 && mark_q) begin
               state_d = S_STOP; exit_d = 1'b1;
            end else begin
               state_d = (lp == LP11) ? S_STOP : S_ERR; err_d = 1'b1;
            end
         end
         S_ULPS: if (wake_start) state_d = S_WAKE;
         S_WAKE: if (chg) begin
            if (lp == LP11 && wake_reached) begin state_d = S_STOP; uex_d = 1'b1; end
            else begin state_d = S_ULPS; err_d = 1'b1; end
         end
         default: state_d = S_ERR;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_INIT;
         phase_q <= PH_CMD;
         mark_q  <= 1'b0;
         rxb_q   <= '0;
         hs_req_o <= 1'b0; esc_req_o <= 1'b0; bta_req_o <= 1'b0;
         ulps_enter_o <= 1'b0; ulps_exit_o <= 1'b0; esc_exit_o <= 1'b0;
         rx_valid_o <= 1'b0; err_o <= 1'b0; trig_o <= '0;
      end else begin
         state_q <= state_d;
         phase_q <= phase_d;
         mark_q  <= mark_d;
         rxb_q   <= rxb_d;
         hs_req_o <= hs_d; esc_req_o <= esc_d; bta_req_o <= bta_d;
         ulps_enter_o <= uen_d; ulps_exit_o <= uex_d; esc_exit_o <= exit_d;
         rx_valid_o <= rxv_d; err_o <= err_d; trig_o <= trig_d;
      end
   end

   assign rx_byte_o = rxb_q;

   lp_mode_e md;
   always_comb begin
      case (state_q)
         S_HS:             md = MD_HS;
         S_TA:             md = MD_TA;
         S_SPACE, S_MARK:  md = (phase_q == PH_DATA) ? MD_LPDT : MD_ESC;
         S_ULPS, S_WAKE:   md = MD_ULPS;
         S_ERR:            md = MD_ERR;
         default:          md = MD_IDLE;
      endcase
   end
   assign mode_o = md;
endmodule

// File: rtl/lpsd_checker.sv
module lpsd_checker
   import lpsd_pkg::*;
#(
   parameter int WAKE_CYCLES = 50000,
   parameter int NUM_TRIG    = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          lp_i,
   input logic [2:0]          mode_o,
   input logic                hs_req_o,
   input logic                esc_req_o,
   input logic                bta_req_o,
   input logic                ulps_enter_o,
   input logic                ulps_exit_o,
   input logic                esc_exit_o,
   input logic [NUM_TRIG-1:0] trig_o,
   input logic                rx_valid_o,
   input logic                err_o
);
   localparam int WCW = $clog2(WAKE_CYCLES + 1);
   localparam logic [WCW-1:0] LIMIT = WCW'(WAKE_CYCLES);

   // independent length of the latest completed Mark-1 run on the raw input
   logic [WCW-1:0] run_q, last_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         last_q <= '0;
      end else if (lp_i == 2'b10) begin
         if (run_q < LIMIT) run_q <= run_q + 1'b1;
      end else begin
         if (run_q != '0) last_q <= run_q;
         run_q <= '0;
      end
   end

   AST_ESC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      esc_req_o |-> mode_o == MD_ESC); // R2
   AST_HS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      hs_req_o |-> mode_o == MD_HS); // R3
   AST_TA_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      bta_req_o |-> mode_o == MD_TA); // R4
   AST_RX_IN_LPDT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> mode_o == MD_LPDT); // R6
   AST_ULPS_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
      ulps_enter_o |-> mode_o == MD_ULPS); // R7
   AST_WAKE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      ulps_exit_o |-> (last_q >= LIMIT && mode_o == MD_IDLE)); // R8
   AST_ESC_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      esc_exit_o |-> (mode_o == MD_IDLE &&
                      ($past(mode_o) == MD_ESC || $past(mode_o) == MD_LPDT))); // R10
   AST_ERR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (mode_o == MD_IDLE || mode_o == MD_ERR || mode_o == MD_ULPS)); // R12
   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hs_req_o, esc_req_o, bta_req_o, ulps_enter_o, ulps_exit_o,
                esc_exit_o, rx_valid_o, err_o, |trig_o})); // R13
endmodule

bind lp_seq_decoder lpsd_checker #(
   .WAKE_CYCLES(WAKE_CYCLES), .NUM_TRIG(NUM_TRIG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lp_i(lp_i), .mode_o(mode_o),
   .hs_req_o(hs_req_o), .esc_req_o(esc_req_o), .bta_req_o(bta_req_o),
   .ulps_enter_o(ulps_enter_o), .ulps_exit_o(ulps_exit_o),
   .esc_exit_o(esc_exit_o), .trig_o(trig_o), .rx_valid_o(rx_valid_o),
   .err_o(err_o)
);

// File: tb/lp_seq_decoder_tb.sv
`timescale 1ns/1ps
module lp_seq_decoder_tb;
   localparam int       WAKE  = 40;
   localparam int       HOLD  = 6;
   localparam logic [7:0] C_LPDT = 8'hE1;
   localparam logic [7:0] C_ULPS = 8'h1E;
   localparam int E_HS = 0, E_ESC = 1, E_BTA = 2, E_UEN = 3, E_UEX = 4,
                  E_EXIT = 5, E_RX = 6, E_ERR = 7, E_T0 = 8, E_T1 = 9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] lp = 2'b11;
   logic [2:0] mode;
   logic       hs, esc, bta, uen, uex, ext, rxv, err;
   logic [1:0] trig;
   logic [7:0] rxb;

   int checks = 0, failures = 0;
   int cnt [10];
   int base [10];
   int multi = 0;
   logic [7:0] rx_log [64];
   int rx_n = 0;

   always #10 clk = ~clk;

   lp_seq_decoder #(
      .SYNC_STAGES(2), .WAKE_CYCLES(WAKE), .CMD_LPDT(C_LPDT), .CMD_ULPS(C_ULPS),
      .NUM_TRIG(2), .TRIG_CODES(16'hA0_62)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .lp_i(lp), .mode_o(mode),
      .hs_req_o(hs), .esc_req_o(esc), .bta_req_o(bta), .ulps_enter_o(uen),
      .ulps_exit_o(uex), .esc_exit_o(ext), .trig_o(trig), .rx_byte_o(rxb),
      .rx_valid_o(rxv), .err_o(err)
   );

   initial for (int i = 0; i < 10; i++) cnt[i] = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (hs)      cnt[E_HS]++;
         if (esc)     cnt[E_ESC]++;
         if (bta)     cnt[E_BTA]++;
         if (uen)     cnt[E_UEN]++;
         if (uex)     cnt[E_UEX]++;
         if (ext)     cnt[E_EXIT]++;
         if (err)     cnt[E_ERR]++;
         if (trig[0]) cnt[E_T0]++;
         if (trig[1]) cnt[E_T1]++;
         if (rxv) begin
            cnt[E_RX]++;
            if (rx_n < 64) rx_log[rx_n] = rxb;
            rx_n++;
         end
         if ($countones({hs, esc, bta, uen, uex, ext, rxv, err, trig}) > 1) multi++;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic snap();
      for (int i = 0; i < 10; i++) base[i] = cnt[i];
   endtask

   function automatic int dlt(input int i);
      return cnt[i] - base[i];
   endfunction

   task automatic drive(input logic [1:0] v, input int n);
      lp = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      drive(b ? 2'b10 : 2'b01, HOLD);
      drive(2'b00, HOLD);
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) send_bit(v[i]);
   endtask

   task automatic esc_entry();
      drive(2'b10, HOLD); drive(2'b00, HOLD); drive(2'b01, HOLD); drive(2'b00, HOLD);
   endtask

   task automatic esc_leave();
      drive(2'b10, HOLD); drive(2'b11, HOLD);
   endtask

   task automatic t_reset();
      check("R1 mode after reset", mode, 0);
      check("R1 pulses after reset", {hs, esc, bta, uen, uex, ext, rxv, err, trig}, 0);
   endtask

   task automatic t_hs();
      snap();
      drive(2'b01, HOLD); drive(2'b00, HOLD);
      check("R3 hs_req count", dlt(E_HS), 1);
      check("R3 mode HS", mode, 4);
      drive(2'b00, 3 * HOLD);
      check("R3 mode held HS", mode, 4);
      drive(2'b11, HOLD);
      check("R3 mode back IDLE", mode, 0);
      check("R3 no error", dlt(E_ERR), 0);
   endtask

   task automatic t_bta();
      snap();
      drive(2'b10, HOLD); drive(2'b00, HOLD); drive(2'b10, HOLD); drive(2'b00, HOLD);
      check("R4 bta_req count", dlt(E_BTA), 1);
      check("R4 no escape", dlt(E_ESC), 0);
      check("R4 mode TA", mode, 5);
      drive(2'b11, HOLD);
      check("R4 mode back IDLE", mode, 0);
   endtask

   task automatic t_lpdt();
      int r0;
      snap();
      r0 = rx_n;
      esc_entry();
      check("R2 esc_req count", dlt(E_ESC), 1);
      check("R2 mode ESC", mode, 1);
      send_byte(C_LPDT);
      check("R6 mode LPDT", mode, 2);
      send_byte(8'h1D);
      send_byte(8'hC8);
      check("R6 rx_valid count", dlt(E_RX), 2);
      check("R5 first byte LSB first", rx_log[r0], 8'h1D);
      check("R6 second byte", rx_log[r0 + 1], 8'hC8);
      esc_leave();
      check("R10 esc_exit count", dlt(E_EXIT), 1);
      check("R10 mode IDLE", mode, 0);
      check("R5 no error", dlt(E_ERR), 0);
   endtask

   task automatic t_ulps();
      snap();
      esc_entry();
      send_byte(C_ULPS);
      check("R7 ulps_enter count", dlt(E_UEN), 1);
      check("R7 mode ULPS", mode, 3);
      drive(2'b10, WAKE / 4); drive(2'b11, HOLD);
      check("R8 short wake error", dlt(E_ERR), 1);
      check("R8 short wake stays ULPS", mode, 3);
      check("R8 short wake no exit", dlt(E_UEX), 0);
      drive(2'b10, 2 * WAKE); drive(2'b11, HOLD);
      check("R8 wake exit count", dlt(E_UEX), 1);
      check("R8 mode IDLE after wake", mode, 0);
   endtask

   task automatic t_trig();
      snap();
      esc_entry();
      send_byte(8'hA0);
      check("R9 trig[1] count", dlt(E_T1), 1);
      check("R9 trig[0] count", dlt(E_T0), 0);
      esc_leave();
      check("R9 exit after trigger", dlt(E_EXIT), 1);
      check("R9 no error", dlt(E_ERR), 0);
   endtask

   task automatic t_badcmd();
      snap();
      esc_entry();
      send_byte(8'h55);
      check("R11 error count", dlt(E_ERR), 1);
      check("R11 mode ERR", mode, 6);
      drive(2'b01, HOLD);
      check("R11 ERR holds", mode, 6);
      drive(2'b11, HOLD);
      check("R11 recover IDLE", mode, 0);
   endtask

   task automatic t_markmark();
      snap();
      esc_entry();
      drive(2'b01, HOLD); drive(2'b10, HOLD);
      check("R12 mark-mark error", dlt(E_ERR), 1);
      check("R12 mode ERR", mode, 6);
      drive(2'b11, HOLD);
      check("R12 recover IDLE", mode, 0);
   endtask

   task automatic t_badentry();
      snap();
      drive(2'b00, HOLD);
      check("R12 stop to LP-00 error", dlt(E_ERR), 1);
      check("R12 mode ERR", mode, 6);
      drive(2'b11, HOLD);
      check("R12 recover", mode, 0);
      drive(2'b10, HOLD); drive(2'b11, HOLD);
      check("R12 abort to stop error", dlt(E_ERR), 2);
      check("R12 abort to stop IDLE", mode, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (HOLD) @(negedge clk);
      t_reset();
      t_hs();
      t_bta();
      t_lpdt();
      t_ulps();
      t_trig();
      t_badcmd();
      t_markmark();
      t_badentry();
      check("R13 one pulse per cycle", multi, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule